// File: doc/BRIEF.md
# Multi-Channel Completion Status Queue

This block gathers completion events from four storage channel engines into a single shared first-in first-out queue. Each channel signals a completion for one cycle, along with an 8-bit device status byte and a 6-bit host status code. Host code 0 stands for a clean completion and code 3 for an error that the device reported. The queue keeps events in the order they arrive. When channels complete in the same cycle, the lower-numbered channel is queued first.

Software drains the queue through a small 32-bit register window. Each entry is read as a pair of words. The word at byte offset 0 carries the device status. The word at byte offset 4 carries four things: a flag that says whether the entry is valid, a flag that says whether the queue will be empty once this read completes, the source channel number, and the host status. A read of the word at offset 4 removes the entry from the queue. Because of this format, a single polling loop can service every channel: it reads both words and repeats until the empty flag is set.

A control word at offset 8 holds the interrupt enable and a sticky overflow indication. The interrupt output is high while the queue holds at least one entry and the enable bit is set.

Top module: `cmpl_status_queue`

## Requirements
- R1: After reset the queue is empty, irq is 0, and the control word reads 0. The word at offset 4 reads 0x8000_0000 and the word at offset 0 reads 0.
- R2: The word at offset 0 carries the head entry's device status in bits 23:16. All of its other bits are 0. It reads 0 while the queue is empty.
- R3: The word at offset 4 carries the head entry's host status in bits 5:0, its channel number in bits 9:8, and a 1 in bit 30 when an entry is present. Bits 29:10 and 7:6 are 0.
- R4: Bit 31 of the word at offset 4 is 1 when the queue holds at most one entry, meaning nothing is left once the current read completes. It is 0 otherwise.
- R5: A read at offset 4 with reg_rd high removes the head entry at that clock edge. Reads at offset 0 or offset 8 leave the queue unchanged.
- R6: Events that arrive in different cycles are read back in arrival order.
- R7: Events that arrive in the same cycle are queued in ascending channel order, channel 0 first.
- R8: A read at offset 4 on an empty queue returns 0x8000_0000, meaning valid is 0 and empty is 1. That read removes nothing and has no effect on events arriving in the same cycle.
- R9: The queue holds 16 entries. An event that finds no free slot is dropped, and all events queued before it are kept. Any drop sets bit 1 of the control word at offset 8. That bit stays set until reset.
- R10: Bit 0 of the control word is the interrupt enable. A write at offset 8 loads it from bit 0 of reg_wdata. irq equals the enable bit AND a non-empty queue.
- R11: In a cycle that has both a removal and new events, free space is counted from the occupancy before the removal. Both operations take effect, so the new events queue behind the remaining entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 4 | Per-channel completion strobe, one cycle per event |
| evt_dev_status | input | 32 | Device status bytes, channel n in bits 8n+7:8n |
| evt_host_status | input | 24 | Host status codes, channel n in bits 6n+5:6n |
| reg_rd | input | 1 | Register read strobe; at offset 4 it removes the head entry |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset within the window (0, 4 or 8) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current reg_addr (combinational) |
| irq | output | 1 | Interrupt: queue non-empty and enable set |

## Verification
The hardest case to reach is a partial overflow. The queue must already hold 15 entries when all four channels complete in the same cycle. Then only channel 0 may be accepted, and the other three must be dropped without disturbing the stored order. The stimulus reaches this point by first filling the queue with three bursts from all four channels and one burst from three channels. It then fires the full burst and drains every entry, comparing each word with a queue-based model that runs every cycle. The same model also covers two other cases: a removal that coincides with new arrivals, and removal attempts on an empty queue.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;
  localparam int NUM_CH   = 4;
  localparam int CH_W     = 2;
  localparam int DEV_W    = 8;
  localparam int HOST_W   = 6;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;

  // Byte offsets inside the register window
  localparam logic [ADDR_W-1:0] OFS_LOWER = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_UPPER = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h8;

  // Field positions used by software
  localparam int POS_EMPTY = 31;
  localparam int POS_VALID = 30;
  localparam int POS_CHAN  = 8;
  localparam int POS_HOST  = 0;
  localparam int POS_DEV   = 16;
  localparam int POS_IEN   = 0;
  localparam int POS_OVF   = 1;

  typedef struct packed {
    logic [CH_W-1:0]   chan;
    logic [DEV_W-1:0]  dev;
    logic [HOST_W-1:0] host;
  } cmpl_entry_t;
endpackage

// File: rtl/cmpl_rank.sv
module cmpl_rank
  import cmpl_pkg::*;
#(
  parameter int NCH    = NUM_CH,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5,
  parameter int RANK_W = 3
) (
  input  logic [NCH-1:0]    evt_valid,
  input  logic [CNT_W-1:0]  occupancy,
  output logic [NCH-1:0]    accept,
  output logic [RANK_W-1:0] rank [NCH],
  output logic [RANK_W-1:0] n_accept,
  output logic              drop
);
  localparam int SUM_W = (CNT_W > RANK_W ? CNT_W : RANK_W) + 1;

  logic [RANK_W-1:0] run;
  logic [SUM_W-1:0]  slot;

  // Each valid event takes the next position after the lower channels' events;
  // it is accepted only when that position still fits in the queue.
  always_comb begin
    run      = '0;
    n_accept = '0;
    slot     = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      rank[ch]   = run;
      slot       = SUM_W'(occupancy) + SUM_W'(run);
      accept[ch] = evt_valid[ch] && (slot < SUM_W'(DEPTH));
      run        = run + RANK_W'(evt_valid[ch]);
      n_accept   = n_accept + RANK_W'(accept[ch]);
    end
    drop = |(evt_valid & ~accept);
  end
endmodule

// File: rtl/cmpl_store.sv
module cmpl_store
  import cmpl_pkg::*;
#(
  parameter int NCH    = NUM_CH,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = 4,
  parameter int CNT_W  = 5,
  parameter int RANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    accept,
  input  logic [RANK_W-1:0] rank [NCH],
  input  cmpl_entry_t       entry_in [NCH],
  input  logic [RANK_W-1:0] n_accept,
  input  logic              pop_req,
  output cmpl_entry_t       head,
  output logic [CNT_W-1:0]  occupancy
);
  cmpl_entry_t      mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] occ_q, occ_d;
  logic             pop;

  always_comb begin
    pop      = pop_req && (occ_q != '0);
    wr_ptr_d = wr_ptr_q + PTR_W'(n_accept);
    rd_ptr_d = rd_ptr_q + PTR_W'(pop);
    occ_d    = occ_q + CNT_W'(n_accept) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
    end
  end

  // Storage array: no reset, written only at accepted slots.
  always_ff @(posedge clk) begin
    for (int ch = 0; ch < NCH; ch++) begin
      if (accept[ch]) begin
        mem[wr_ptr_q + PTR_W'(rank[ch])] <= entry_in[ch];
      end
    end
  end

  assign head      = mem[rd_ptr_q];
  assign occupancy = occ_q;
endmodule

// File: rtl/cmpl_regif.sv
module cmpl_regif
  import cmpl_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  cmpl_entry_t       head,
  input  logic [CNT_W-1:0]  occupancy,
  input  logic              drop,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pop_req,
  output logic              ovf_flag,
  output logic              irq
);
  logic ien_q, ien_d;
  logic ovf_q, ovf_d;
  logic have_entry, last_entry;
  logic [DATA_W-1:0] lower_word, upper_word, ctrl_word;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:1];

  always_comb begin
    ien_d = ien_q;
    if (reg_wr && reg_addr == OFS_CTRL) ien_d = reg_wdata[POS_IEN];
    ovf_d = ovf_q | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      ien_q <= ien_d;
      ovf_q <= ovf_d;
    end
  end

  always_comb begin
    have_entry = (occupancy != '0);
    last_entry = (occupancy <= CNT_W'(1));
    lower_word = '0;
    upper_word = '0;
    ctrl_word  = '0;
    upper_word[POS_EMPTY] = last_entry;
    if (have_entry) begin
      lower_word[POS_DEV +: DEV_W]   = head.dev;
      upper_word[POS_VALID]          = 1'b1;
      upper_word[POS_CHAN +: CH_W]   = head.chan;
      upper_word[POS_HOST +: HOST_W] = head.host;
    end
    ctrl_word[POS_IEN] = ien_q;
    ctrl_word[POS_OVF] = ovf_q;
    case (reg_addr)
      OFS_LOWER: reg_rdata = lower_word;
      OFS_UPPER: reg_rdata = upper_word;
      OFS_CTRL:  reg_rdata = ctrl_word;
      default:   reg_rdata = '0;
    endcase
  end

  assign pop_req  = reg_rd && (reg_addr == OFS_UPPER);
  assign ovf_flag = ovf_q;
  assign irq      = ien_q && have_entry;
endmodule

// File: rtl/cmpl_status_queue.sv
module cmpl_status_queue
  import cmpl_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        evt_valid,
  input  logic [NUM_CH*DEV_W-1:0]  evt_dev_status,
  input  logic [NUM_CH*HOST_W-1:0] evt_host_status,
  input  logic                     reg_rd,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic                     irq
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = PTR_W + 1;
  localparam int RANK_W = $clog2(NUM_CH + 1);

  cmpl_entry_t       entry_in [NUM_CH];
  logic [NUM_CH-1:0] accept;
  logic [RANK_W-1:0] rank [NUM_CH];
  logic [RANK_W-1:0] n_accept;
  logic              drop;
  logic              pop_req;
  cmpl_entry_t       head;
  logic [CNT_W-1:0]  occupancy;
  logic              ovf_flag;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
    assign entry_in[g].chan = CH_W'(g);
    assign entry_in[g].dev  = evt_dev_status[g*DEV_W +: DEV_W];
    assign entry_in[g].host = evt_host_status[g*HOST_W +: HOST_W];
  end

  cmpl_rank #(
    .NCH(NUM_CH), .DEPTH(DEPTH), .CNT_W(CNT_W), .RANK_W(RANK_W)
  ) u_rank (
    .evt_valid(evt_valid), .occupancy(occupancy), .accept(accept),
    .rank(rank), .n_accept(n_accept), .drop(drop)
  );

  cmpl_store #(
    .NCH(NUM_CH), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W), .RANK_W(RANK_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rank(rank),
    .entry_in(entry_in), .n_accept(n_accept), .pop_req(pop_req),
    .head(head), .occupancy(occupancy)
  );

  cmpl_regif #(
    .CNT_W(CNT_W)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .head(head),
    .occupancy(occupancy), .drop(drop), .reg_rdata(reg_rdata),
    .pop_req(pop_req), .ovf_flag(ovf_flag), .irq(irq)
  );
endmodule

// File: rtl/cmpl_checker.sv
module cmpl_checker
  import cmpl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] evt_valid,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  occupancy,
  input logic              ovf_flag
);
  logic upper_rd;
  assign upper_rd = reg_rd && (reg_addr == OFS_UPPER);

  // R9: occupancy never exceeds the depth
  a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));

  // R9: overflow indication is sticky
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  // R8: an entry-less upper word always reports empty
  a_r8_invalid_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_UPPER && !reg_rdata[POS_VALID]) |-> reg_rdata[POS_EMPTY]);

  // R5: reading a valid upper word removes exactly one entry when nothing arrives
  a_r5_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (upper_rd && reg_rdata[POS_VALID] && evt_valid == '0)
      |=> occupancy == $past(occupancy) - CNT_W'(1));

  // R4/R10: reading the last entry with no arrivals drops the interrupt
  a_r4_last_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (upper_rd && reg_rdata[POS_EMPTY] && evt_valid == '0) |=> !irq);

  // R5: lower and control reads leave occupancy alone when nothing arrives
  a_r5_no_pop_other: assert property (@(posedge clk) disable iff (!rst_n)
    (!upper_rd && evt_valid == '0) |=> $stable(occupancy));
endmodule

bind cmpl_status_queue cmpl_checker #(
  .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq(irq),
  .occupancy(occupancy), .ovf_flag(ovf_flag)
);

// File: tb/test_cmpl_status_queue.sv
`timescale 1ns/1ps
module test_cmpl_status_queue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  evt_valid;
  logic [31:0] evt_dev_status;
  logic [23:0] evt_host_status;
  logic        reg_rd, reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // model state: entry = {chan[1:0], dev[7:0], host[5:0]}
  logic [15:0] q[$];
  bit m_ien = 0;
  bit m_ovf = 0;

  always #10 clk = ~clk;

  cmpl_status_queue i_cmpl_status_queue (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid),
    .evt_dev_status(evt_dev_status), .evt_host_status(evt_host_status),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_word(input logic [3:0] a);
    logic [31:0] w;
    w = '0;
    if (a == 4'h0) begin
      if (q.size() != 0) w[23:16] = q[0][13:6];
    end else if (a == 4'h4) begin
      w[31] = (q.size() <= 1);
      if (q.size() != 0) begin
        w[30]  = 1'b1;
        w[9:8] = q[0][15:14];
        w[5:0] = q[0][5:0];
      end
    end else if (a == 4'h8) begin
      w[0] = m_ien;
      w[1] = m_ovf;
    end
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one cycle: drive after negedge, compare combinational outputs, model the edge
  task automatic step(input string tag, input logic [3:0] v, input int seed,
                      input logic rd, input logic wr, input logic [3:0] a,
                      input logic [31:0] wd);
    int n0, rk;
    bit do_pop;
    evt_valid = v;
    for (int c = 0; c < 4; c++) begin
      evt_dev_status[c*8 +: 8]  = 8'(seed * 37 + c * 11 + 5);
      evt_host_status[c*6 +: 6] = 6'(seed * 3 + c * 5);
    end
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    #1;
    check({tag, " rdata"}, reg_rdata, exp_word(a));
    check({tag, " irq R10"}, {31'b0, irq}, {31'b0, (m_ien && q.size() != 0)});
    @(posedge clk);
    n0 = q.size();
    do_pop = rd && (a == 4'h4) && (n0 > 0);
    rk = 0;
    for (int c = 0; c < 4; c++) begin
      if (v[c]) begin
        if (n0 + rk < 16)
          q.push_back({2'(c), evt_dev_status[c*8 +: 8], evt_host_status[c*6 +: 6]});
        else
          m_ovf = 1;
        rk++;
      end
    end
    if (do_pop) void'(q.pop_front());
    if (wr && a == 4'h8) m_ien = wd[0];
    @(negedge clk);
    evt_valid = '0; reg_rd = 0; reg_wr = 0;
  endtask

  task automatic drain(input string tag);
    int n;
    n = q.size();
    for (int k = 0; k < n; k++) begin
      step({tag, " lower R2"}, 4'h0, 0, 1'b1, 1'b0, 4'h0, 0);
      step({tag, " upper R3 R4 R5"}, 4'h0, 0, 1'b1, 1'b0, 4'h4, 0);
    end
    step({tag, " empty R8"}, 4'h0, 0, 1'b1, 1'b0, 4'h4, 0);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; evt_valid = '0; evt_dev_status = '0; evt_host_status = '0;
    reg_rd = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    step("R1 upper", 4'h0, 0, 1'b0, 1'b0, 4'h4, 0);
    step("R1 lower", 4'h0, 0, 1'b0, 1'b0, 4'h0, 0);
    step("R1 ctrl",  4'h0, 0, 1'b0, 1'b0, 4'h8, 0);
    // R10 enable interrupt
    step("R10 write en", 4'h0, 0, 1'b0, 1'b1, 4'h8, 32'hFFFF_FFFF);
    step("R10 ctrl", 4'h0, 0, 1'b0, 1'b0, 4'h8, 0);
    // single event, lower reads do not pop
    step("R6 single", 4'h4, 1, 1'b0, 1'b0, 4'h4, 0);
    step("R5 lower read", 4'h0, 0, 1'b1, 1'b0, 4'h0, 0);
    step("R5 lower again", 4'h0, 0, 1'b1, 1'b0, 4'h0, 0);
    step("R5 ctrl read", 4'h0, 0, 1'b1, 1'b0, 4'h8, 0);
    drain("R4 single");
    // R8 pops on empty are ignored
    step("R8 empty pop", 4'h0, 0, 1'b1, 1'b0, 4'h4, 0);
    step("R8 empty lower", 4'h0, 0, 1'b0, 1'b0, 4'h0, 0);
    // R6 arrival order over cycles
    step("R6 ev a", 4'h2, 2, 1'b0, 1'b0, 4'h4, 0);
    step("R6 ev b", 4'h8, 3, 1'b0, 1'b0, 4'h4, 0);
    step("R6 ev c", 4'h1, 4, 1'b0, 1'b0, 4'h4, 0);
    drain("R6 order");
    // R7 same cycle priority
    step("R7 burst", 4'hF, 5, 1'b0, 1'b0, 4'h4, 0);
    step("R7 burst2", 4'hA, 6, 1'b0, 1'b0, 4'h4, 0);
    drain("R7 priority");
    // R9 fill to 15 then partial overflow
    step("R9 fill1", 4'hF, 7, 1'b0, 1'b0, 4'h4, 0);
    step("R9 fill2", 4'hF, 8, 1'b0, 1'b0, 4'h4, 0);
    step("R9 fill3", 4'hF, 9, 1'b0, 1'b0, 4'h4, 0);
    step("R9 fill4", 4'h7, 10, 1'b0, 1'b0, 4'h8, 0);
    step("R9 over", 4'hF, 11, 1'b0, 1'b0, 4'h8, 0);
    step("R9 ctrl", 4'h0, 0, 1'b0, 1'b0, 4'h8, 0);
    step("R9 full upper", 4'h3, 12, 1'b0, 1'b0, 4'h4, 0);
    // R11 pop while full and event in same cycle: capacity counted before pop
    step("R11 full pop+ev", 4'h1, 13, 1'b1, 1'b0, 4'h4, 0);
    drain("R9 drain");
    step("R9 ctrl sticky", 4'h0, 0, 1'b0, 1'b0, 4'h8, 0);
    // R11 pop and event same cycle on non-full queue
    step("R11 seed", 4'h1, 14, 1'b0, 1'b0, 4'h4, 0);
    step("R11 pop+ev", 4'h6, 15, 1'b1, 1'b0, 4'h4, 0);
    step("R8 empty pop+ev", 4'h0, 0, 1'b0, 1'b0, 4'h4, 0);
    drain("R11 drain");
    step("R8 pop with ev on empty", 4'h8, 16, 1'b1, 1'b0, 4'h4, 0);
    // R10 disable interrupt with entry present
    step("R10 disable", 4'h0, 0, 1'b0, 1'b1, 4'h8, 32'h0);
    step("R10 masked", 4'h0, 0, 1'b0, 1'b0, 4'h8, 0);
    step("R10 reenable", 4'h0, 0, 1'b0, 1'b1, 4'h8, 32'h1);
    drain("R10 drain");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule